// File: doc/BRIEF.md
# Descriptor Chaining Sequencer

This block is the control sequencer of one I/O subchannel. When started with the address of a descriptor list, it reads two-word transfer descriptors from memory and loads the operational one into the subchannel's working registers. It then lets the device move bytes, one per accepted strobe. Each byte decrements the byte count and steps the byte address. When the count reaches zero, the descriptor's flags choose what happens next. Data chaining reloads the next descriptor inside the same order. Command chaining ends the order and starts a new one from the next descriptor. With neither flag set, the sequencer finishes and goes idle.

A transfer-in-channel descriptor carries the jump code and acts only as a pointer: the sequencer continues fetching at the address held in its word 0. Such jumps and data-chained reloads are invisible to the device. The order-active indication stays high throughout, no order-start pulse is given, and any change of skip flag or write key simply appears on the working-register outputs. If the zero-count interrupt flag is set, a one-cycle interrupt request is raised when the count reaches zero, and it does not hold up the next fetch. Two jump descriptors in a row abort the chain with a program-check pulse.

Top module: `desc_chain_seq`

## Requirements
- R1: After synchronous reset, seq_busy, order_active, dev_ready, mem_req, order_new, order_end, irq_req and prog_check are all 0.
- R2: On start in idle, the sequencer reads word 0 at the descriptor address and then word 1 at that address plus 4. Each read holds mem_req and mem_addr steady until mem_ack. Word 0 bits 31:24 hold the order code and bits 23:0 the byte address. Word 1 bit 31 is data chain, bit 30 command chain, bit 29 zero-count interrupt, bit 28 skip, bits 27:24 the write key and bits 15:0 the byte count.
- R3: dev_ready is 1 only while an operational descriptor is executing with a nonzero count. Each cycle with dev_ready and dev_strobe both 1 decrements cur_count by 1 and increments cur_addr by 1. For order code 0x0C (backward) it decrements cur_addr by 1 instead.
- R4: At zero count with data chain set, the descriptor at the current descriptor address plus 8 is fetched. order_active stays 1, and no order_end or order_new pulse is given.
- R5: The skip flag and write key of a newly loaded descriptor appear on cur_skip and cur_wkey without any other indication. They stay unchanged while no descriptor is loaded.
- R6: A descriptor with order code 0x08 (jump) is not executed. The next fetch is taken from the address in its word 0 bits 23:0, and later sequential fetches continue from there.
- R7: A jump descriptor that immediately follows another jump descriptor gives a one-cycle prog_check pulse, returns the sequencer to idle and clears order_active.
- R8: When the count reaches zero and the zero-count interrupt flag is 1, irq_req pulses for one cycle, whether or not chaining is set. A chained fetch begins in the cycle after that pulse.
- R9: At zero count with data chain 0, order_end pulses for one cycle and order_active falls in the same cycle. If command chain is also 0, the sequencer returns to idle.
- R10: At zero count with data chain 0 and command chain 1, the next descriptor at plus 8 is fetched. order_new pulses when it begins executing, just as for an order started by start.
- R11: A descriptor loaded with a byte count of 0 reaches zero-count handling at once and accepts no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a descriptor list (taken in idle) |
| start_addr | input | 24 | Address of the first descriptor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read byte address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data word |
| dev_strobe | input | 1 | Device moves one byte |
| dev_ready | output | 1 | Subchannel can accept a byte |
| cur_code | output | 8 | Order code of current descriptor |
| cur_addr | output | 24 | Current byte address |
| cur_count | output | 16 | Remaining byte count |
| cur_skip | output | 1 | Skip flag of current descriptor |
| cur_wkey | output | 4 | Write key of current descriptor |
| order_active | output | 1 | An order is in progress |
| order_new | output | 1 | Pulse: a new order starts executing |
| order_end | output | 1 | Pulse: order completed normally |
| irq_req | output | 1 | Pulse: zero-count interrupt request |
| prog_check | output | 1 | Pulse: chain aborted by double jump |
| seq_busy | output | 1 | Sequencer is not idle |

## Verification
The lists used are a lone descriptor, a data-chained pair with different skip and key, a data chain that passes through a jump to a backward descriptor, a command-chained pair, a double jump both before any order and inside a data chain, and a zero-count descriptor. The fetch addresses show sequential stepping apart from jump redirection. The order of new, interrupt, end and drop events shows a data-chain reload apart from a command-chain boundary. Per-byte address, skip and key show forward stepping apart from backward stepping, and show when a reload takes effect. A gapped device strobe pattern checks that counting follows accepted bytes and not clock cycles.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FW0, S_FW1, S_DECODE, S_EXEC, S_DONE
  } seq_state_t;

  localparam int CODE_HI   = 31;
  localparam int CODE_LO   = 24;
  localparam int FLAG_DC   = 31;
  localparam int FLAG_CC   = 30;
  localparam int FLAG_IZC  = 29;
  localparam int FLAG_SKIP = 28;
  localparam int KEY_LO    = 24;
endpackage

// File: rtl/dcs_xfer.sv
module dcs_xfer #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int KW = 4,
  parameter logic [7:0] BACK_CODE = 8'h0C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [31:0]   w0,
  input  logic [31:0]   w1,
  input  logic          exec,
  input  logic          dev_strobe,
  output logic          dev_ready,
  output logic [7:0]    cur_code,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          cur_skip,
  output logic [KW-1:0] cur_wkey,
  output logic          cur_dc,
  output logic          cur_cc,
  output logic          cur_izc,
  output logic          cnt_zero
);
  import dcs_pkg::*;

  logic take;
  logic unused_rsv;

  assign unused_rsv = ^w1[KEY_LO-1:CW];
  assign dev_ready  = exec && (cur_count != '0);
  assign cnt_zero   = (cur_count == '0);
  assign take       = dev_ready && dev_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_code  <= '0;
      cur_addr  <= '0;
      cur_count <= '0;
      cur_skip  <= 1'b0;
      cur_wkey  <= '0;
      cur_dc    <= 1'b0;
      cur_cc    <= 1'b0;
      cur_izc   <= 1'b0;
    end else if (load) begin
      cur_code  <= w0[CODE_HI:CODE_LO];
      cur_addr  <= w0[AW-1:0];
      cur_count <= w1[CW-1:0];
      cur_skip  <= w1[FLAG_SKIP];
      cur_wkey  <= w1[KEY_LO +: KW];
      cur_dc    <= w1[FLAG_DC];
      cur_cc    <= w1[FLAG_CC];
      cur_izc   <= w1[FLAG_IZC];
    end else if (take) begin
      cur_count <= cur_count - CW'(1);
      if (cur_code == BACK_CODE) cur_addr <= cur_addr - AW'(1);
      else                       cur_addr <= cur_addr + AW'(1);
    end
  end

  // R3: an accepted byte lowers the count by exactly one
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (take && !load) |=> cur_count == $past(cur_count) - CW'(1));

  // R3: address moves by one in the direction the code selects
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (take && !load) |=> (cur_addr == $past(cur_addr) + AW'(1)) ||
                        (cur_addr == $past(cur_addr) - AW'(1)));

  // R5: skip and key only change on a descriptor load
  p_attr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur_skip) && $stable(cur_wkey));
endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm #(
  parameter int AW = 24,
  parameter logic [7:0] JUMP_CODE = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          cnt_zero,
  input  logic          cur_dc,
  input  logic          cur_cc,
  input  logic          cur_izc,
  output logic [31:0]   w0,
  output logic [31:0]   w1,
  output logic          load,
  output logic          exec,
  output logic          order_active,
  output logic          order_new,
  output logic          order_end,
  output logic          irq_req,
  output logic          prog_check,
  output logic          seq_busy
);
  import dcs_pkg::*;

  localparam logic [AW-1:0] DESC_STEP = AW'(8);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  seq_state_t    state;
  logic [AW-1:0] ptr;
  logic          jump_prev;
  logic          new_pend;
  logic          is_jump;

  assign is_jump  = (w0[CODE_HI:CODE_LO] == JUMP_CODE);
  assign load     = (state == S_DECODE) && !is_jump;
  assign exec     = (state == S_EXEC);
  assign mem_req  = (state == S_FW0) || (state == S_FW1);
  assign mem_addr = (state == S_FW1) ? ptr + WORD_STEP : ptr;
  assign seq_busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      ptr          <= '0;
      w0           <= '0;
      w1           <= '0;
      jump_prev    <= 1'b0;
      new_pend     <= 1'b0;
      order_active <= 1'b0;
      order_new    <= 1'b0;
      order_end    <= 1'b0;
      irq_req      <= 1'b0;
      prog_check   <= 1'b0;
    end else begin
      order_new  <= 1'b0;
      order_end  <= 1'b0;
      irq_req    <= 1'b0;
      prog_check <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          ptr       <= start_addr;
          jump_prev <= 1'b0;
          new_pend  <= 1'b1;
          state     <= S_FW0;
        end
        S_FW0: if (mem_ack) begin
          w0    <= mem_rdata;
          state <= S_FW1;
        end
        S_FW1: if (mem_ack) begin
          w1    <= mem_rdata;
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (is_jump) begin
            if (jump_prev) begin
              prog_check   <= 1'b1;
              order_active <= 1'b0;
              state        <= S_IDLE;
            end else begin
              ptr       <= w0[AW-1:0];
              jump_prev <= 1'b1;
              state     <= S_FW0;
            end
          end else begin
            jump_prev <= 1'b0;
            state     <= S_EXEC;
            if (new_pend) begin
              order_new    <= 1'b1;
              order_active <= 1'b1;
              new_pend     <= 1'b0;
            end
          end
        end
        S_EXEC: if (cnt_zero) begin
          irq_req <= cur_izc;
          state   <= S_DONE;
          if (!cur_dc) begin
            order_end    <= 1'b1;
            order_active <= 1'b0;
          end
        end
        S_DONE: begin
          if (cur_dc || cur_cc) begin
            ptr      <= ptr + DESC_STEP;
            new_pend <= !cur_dc;
            state    <= S_FW0;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a pending read keeps its request and address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));

  // R4 and R9: the order indication only falls on completion or abort
  p_active_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(order_active) |-> (order_end || prog_check));

  // R8: the interrupt request is a single-cycle pulse
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  // R8: a chained fetch is not delayed by the interrupt
  p_no_delay_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && (cur_dc || cur_cc)) |=> mem_req);

  // R7: an abort leaves the sequencer idle
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (rst)
    prog_check |-> !seq_busy && !order_active);

  // R10: a new order never coincides with a completion
  p_new_excl_r10: assert property (@(posedge clk) disable iff (rst)
    order_new |-> !order_end && order_active);
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int KW = 4,
  parameter logic [7:0] JUMP_CODE = 8'h08,
  parameter logic [7:0] BACK_CODE = 8'h0C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          dev_strobe,
  output logic          dev_ready,
  output logic [7:0]    cur_code,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          cur_skip,
  output logic [KW-1:0] cur_wkey,
  output logic          order_active,
  output logic          order_new,
  output logic          order_end,
  output logic          irq_req,
  output logic          prog_check,
  output logic          seq_busy
);
  logic [31:0] w0, w1;
  logic        load, exec, cnt_zero;
  logic        cur_dc, cur_cc, cur_izc;

  dcs_fsm #(.AW(AW), .JUMP_CODE(JUMP_CODE)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .cnt_zero(cnt_zero), .cur_dc(cur_dc),
    .cur_cc(cur_cc), .cur_izc(cur_izc), .w0(w0), .w1(w1), .load(load),
    .exec(exec), .order_active(order_active), .order_new(order_new),
    .order_end(order_end), .irq_req(irq_req), .prog_check(prog_check),
    .seq_busy(seq_busy)
  );

  dcs_xfer #(.AW(AW), .CW(CW), .KW(KW), .BACK_CODE(BACK_CODE)) u_xfer (
    .clk(clk), .rst(rst), .load(load), .w0(w0), .w1(w1), .exec(exec),
    .dev_strobe(dev_strobe), .dev_ready(dev_ready), .cur_code(cur_code),
    .cur_addr(cur_addr), .cur_count(cur_count), .cur_skip(cur_skip),
    .cur_wkey(cur_wkey), .cur_dc(cur_dc), .cur_cc(cur_cc),
    .cur_izc(cur_izc), .cnt_zero(cnt_zero)
  );

  // R11: no byte is offered once the count is zero
  p_zero_no_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (cur_count == '0) |-> !dev_ready);
endmodule

// File: tb/sim_desc_chain_seq.sv
module sim_desc_chain_seq;
  localparam int K_FETCH = 7, K_NEW = 1, K_BYTE = 2, K_IRQ = 3,
                 K_END = 4, K_DROP = 5, K_PCHK = 6;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        mem_req, mem_ack, dev_strobe, dev_ready;
  logic [23:0] mem_addr, cur_addr;
  logic [31:0] mem_rdata;
  logic [7:0]  cur_code;
  logic [15:0] cur_count;
  logic        cur_skip;
  logic [3:0]  cur_wkey;
  logic        order_active, order_new, order_end, irq_req, prog_check, seq_busy;

  logic [31:0] mem [0:255];
  logic [35:0] exp_q [$];
  string       tag_q [$];
  int total = 0, bad = 0;
  logic gap_en = 1'b0, prev_active = 1'b0;
  int   cyc = 0;

  always #2.5 clk = ~clk;

  desc_chain_seq u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .dev_strobe(dev_strobe), .dev_ready(dev_ready),
    .cur_code(cur_code), .cur_addr(cur_addr), .cur_count(cur_count),
    .cur_skip(cur_skip), .cur_wkey(cur_wkey), .order_active(order_active),
    .order_new(order_new), .order_end(order_end), .irq_req(irq_req),
    .prog_check(prog_check), .seq_busy(seq_busy)
  );

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    dev_strobe = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  end

  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] ev(input int k, input logic [31:0] v);
    return {4'(k), v};
  endfunction

  task automatic push(input int k, input logic [31:0] v, input string tag);
    exp_q.push_back(ev(k, v));
    tag_q.push_back(tag);
  endtask

  task automatic observe(input int k, input logic [31:0] v);
    if (exp_q.size() == 0) begin
      check("R? unexpected event", ev(k, v), '0);
    end else begin
      logic [35:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, ev(k, v), e);
    end
  endtask

  // monitor and device model, away from the active edge
  always @(negedge clk) begin
    logic s;
    cyc++;
    if (!rst) begin
      if (mem_req && mem_ack) observe(K_FETCH, {8'h0, mem_addr});
      if (order_new) observe(K_NEW, {24'h0, cur_code});
      s = dev_ready && (!gap_en || cyc[0]);
      if (s) observe(K_BYTE, {3'b0, cur_skip, cur_wkey, cur_addr});
      if (irq_req) observe(K_IRQ, 32'h0);
      if (order_end) observe(K_END, 32'h0);
      if (prev_active && !order_active) observe(K_DROP, 32'h0);
      if (prog_check) observe(K_PCHK, 32'h0);
      prev_active = order_active;
      dev_strobe = s;
    end
  end

  task automatic put_desc(input logic [23:0] at, input logic [7:0] code,
                          input logic [23:0] ba, input logic [3:0] flags,
                          input logic [3:0] key, input logic [15:0] cnt);
    mem[at[9:2]]     = {code, ba};
    mem[at[9:2] + 1] = {flags, key, 8'h00, cnt};
  endtask

  task automatic exp_fetch(input logic [23:0] at, input string tag);
    push(K_FETCH, {8'h0, at}, tag);
    push(K_FETCH, {8'h0, at + 24'd4}, tag);
  endtask

  task automatic exp_bytes(input logic [23:0] a, input int n, input logic back,
                           input logic sk, input logic [3:0] key, input string tag);
    for (int i = 0; i < n; i++)
      push(K_BYTE, {3'b0, sk, key, back ? a - 24'(i) : a + 24'(i)}, tag);
  endtask

  task automatic run(input logic [23:0] at, input string tag);
    @(negedge clk);
    start_addr = at;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && seq_busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " pending events"}, 36'(exp_q.size()), 36'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 36'(seq_busy), 36'd0);
    check("R1 active", 36'(order_active), 36'd0);
    check("R1 ready", 36'(dev_ready), 36'd0);
    check("R1 req", 36'(mem_req), 36'd0);
    check("R1 pulses", 36'({order_new, order_end, irq_req, prog_check}), 36'd0);

    // R2 R3 R9: single descriptor, forward
    put_desc(24'h040, 8'h02, 24'h001000, 4'b0000, 4'h3, 16'd3);
    exp_fetch(24'h040, "R2 fetch");
    push(K_NEW, 32'h02, "R2 new");
    exp_bytes(24'h001000, 3, 1'b0, 1'b0, 4'h3, "R3 fwd byte");
    push(K_END, 0, "R9 end");
    push(K_DROP, 0, "R9 drop");
    run(24'h040, "R9");

    // R4 R5 R8: data chain with irq, gapped strobes
    gap_en = 1'b1;
    put_desc(24'h080, 8'h01, 24'h002000, 4'b1010, 4'h1, 16'd2);
    put_desc(24'h088, 8'h01, 24'h003000, 4'b0001, 4'h5, 16'd2);
    exp_fetch(24'h080, "R2 fetch");
    push(K_NEW, 32'h01, "R4 new");
    exp_bytes(24'h002000, 2, 1'b0, 1'b0, 4'h1, "R5 first attr");
    push(K_IRQ, 0, "R8 irq on chain");
    exp_fetch(24'h088, "R4 chained fetch");
    exp_bytes(24'h003000, 2, 1'b0, 1'b1, 4'h5, "R5 switched attr");
    push(K_END, 0, "R4 end once");
    push(K_DROP, 0, "R4 drop once");
    run(24'h080, "R4");
    gap_en = 1'b0;

    // R6 R3: jump inside a data chain to a backward descriptor
    put_desc(24'h100, 8'h01, 24'h004000, 4'b1000, 4'h2, 16'd2);
    put_desc(24'h108, 8'h08, 24'h000180, 4'b0000, 4'h0, 16'd0);
    put_desc(24'h180, 8'h0C, 24'h000500, 4'b0000, 4'h2, 16'd3);
    exp_fetch(24'h100, "R2 fetch");
    push(K_NEW, 32'h01, "R6 new");
    exp_bytes(24'h004000, 2, 1'b0, 1'b0, 4'h2, "R6 bytes");
    exp_fetch(24'h108, "R6 jump fetch");
    exp_fetch(24'h180, "R6 redirected");
    exp_bytes(24'h000500, 3, 1'b1, 1'b0, 4'h2, "R3 back byte");
    push(K_END, 0, "R6 end");
    push(K_DROP, 0, "R6 drop");
    run(24'h100, "R6");

    // R10: command chain
    put_desc(24'h300, 8'h04, 24'h006000, 4'b0100, 4'h7, 16'd1);
    put_desc(24'h308, 8'h04, 24'h007000, 4'b0000, 4'h7, 16'd2);
    exp_fetch(24'h300, "R2 fetch");
    push(K_NEW, 32'h04, "R10 first new");
    exp_bytes(24'h006000, 1, 1'b0, 1'b0, 4'h7, "R10 bytes");
    push(K_END, 0, "R10 end");
    push(K_DROP, 0, "R10 drop");
    exp_fetch(24'h308, "R10 next fetch");
    push(K_NEW, 32'h04, "R10 second new");
    exp_bytes(24'h007000, 2, 1'b0, 1'b0, 4'h7, "R10 bytes2");
    push(K_END, 0, "R10 end2");
    push(K_DROP, 0, "R10 drop2");
    run(24'h300, "R10");

    // R7: double jump before any order
    put_desc(24'h200, 8'h08, 24'h000210, 4'b0000, 4'h0, 16'd0);
    put_desc(24'h210, 8'h08, 24'h000220, 4'b0000, 4'h0, 16'd0);
    exp_fetch(24'h200, "R7 fetch");
    exp_fetch(24'h210, "R7 fetch2");
    push(K_PCHK, 0, "R7 abort");
    run(24'h200, "R7a");
    check("R7 idle", 36'(seq_busy), 36'd0);

    // R7: double jump inside a data chain
    put_desc(24'h240, 8'h01, 24'h008000, 4'b1000, 4'h0, 16'd1);
    put_desc(24'h248, 8'h08, 24'h000260, 4'b0000, 4'h0, 16'd0);
    put_desc(24'h260, 8'h08, 24'h000270, 4'b0000, 4'h0, 16'd0);
    exp_fetch(24'h240, "R2 fetch");
    push(K_NEW, 32'h01, "R7 new");
    exp_bytes(24'h008000, 1, 1'b0, 1'b0, 4'h0, "R7 bytes");
    exp_fetch(24'h248, "R7 fetch3");
    exp_fetch(24'h260, "R7 fetch4");
    push(K_DROP, 0, "R7 drop");
    push(K_PCHK, 0, "R7 abort2");
    run(24'h240, "R7b");

    // R11 R8: zero count with interrupt
    put_desc(24'h2C0, 8'h03, 24'h009000, 4'b0010, 4'h0, 16'd0);
    exp_fetch(24'h2C0, "R2 fetch");
    push(K_NEW, 32'h03, "R11 new");
    push(K_IRQ, 0, "R8 irq zero");
    push(K_END, 0, "R11 end");
    push(K_DROP, 0, "R11 drop");
    run(24'h2C0, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule